// File: doc/BRIEF.md
# Clock Generator Startup Sequencer with Strap Capture

This block brings a clock generator out of power-up in a fixed order. It first waits for its own supply to report good. It then counts a settling window on an external time-base tick, and during that window the power-good strobe is not looked at. Next it waits for the active-low power-good strobe. On the first low sample of that strobe it captures the configuration straps and starts the VCO and the clock outputs. From then on the straps and the strobe are ignored until reset.

The straps are two binary frequency-select pins, one three-level mode pin and a current-multiplier pin. The three-level pin arrives already decoded as two bits: "high" and "mid". The captured straps are decoded into a CPU frequency in MHz, a flag that says whether the 66 MHz group is taken from the external input, and two mode flags for three-state and test operation. Every asynchronous input passes through a synchronizer of `SYNC_STAGES` flops. The settling window is `SETTLE_TICKS` ticks long. With a 1 µs tick the default gives 0.25 ms.

Top module: `clkgen_startup_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `vco_en`, `out_en`, `strap_word`, `cpu_mhz`, `src_external`, `tristate_mode` and `test_mode` are all zero.
- R2: Ticks that arrive before the synchronized `supply_ok` has been seen are not counted. Once the supply is seen, the settling window ends on the edge that samples the `SETTLE_TICKS`-th tick. If `pg_n` has been low throughout, `vco_en` rises exactly one clock edge after that final tick edge and not earlier.
- R3: Low pulses on `pg_n` during the settling window are ignored. If `pg_n` stays high after the window, the block keeps waiting with `vco_en`, `out_en` and `strap_word` at zero.
- R4: While the block is waiting, a falling `pg_n` produces captured outputs `SYNC_STAGES`+1 edges later and not before. The captured straps are the ones that were stable during the `SYNC_STAGES` cycles before the fall, not values seen earlier in the window.
- R5: After capture, changes on `pg_n`, `sel_lo`, `sel_hi_high`, `sel_hi_mid` and `mult_sel` leave every output unchanged until reset.
- R6: When the mid bit is clear, `cpu_mhz` follows `sel_lo`: 0 gives 66, 1 gives 100, 2 gives 200 and 3 gives 133.
- R7: When the mid bit is clear, `src_external` equals the captured high bit (1 = external 66 MHz input, PCI at half of it; 0 = internal VCO). When the mid bit is set, `src_external` is 0.
- R8: When the mid bit is set, it takes priority over the high bit. `sel_lo` = 1 sets `test_mode` and forces `cpu_mhz` to 200. The other three codes (0, and the reserved 2 and 3) set `tristate_mode`, and `cpu_mhz` keeps the R6 mapping. The two mode flags are never set together.
- R9: `strap_word` holds the captured straps: bits [1:0] `sel_lo`, bit 2 the high bit, bit 3 the mid bit, bit 4 `mult_sel`.
- R10: Once the straps are captured, `vco_en` is 1 and stays 1 until reset. `out_en` equals the inverse of `tristate_mode`. `out_en` is never 1 without `vco_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse that paces the settling window |
| supply_ok | input | 1 | Block supply good, asynchronous |
| pg_n | input | 1 | Power-good strobe, active low, asynchronous |
| sel_lo | input | 2 | Binary frequency-select straps |
| sel_hi_high | input | 1 | Three-level mode strap decoded as high |
| sel_hi_mid | input | 1 | Three-level mode strap decoded as mid |
| mult_sel | input | 1 | Current-multiplier strap |
| strap_word | output | 5 | Captured straps, layout per R9 |
| cpu_mhz | output | 8 | Decoded CPU frequency in MHz |
| src_external | output | 1 | 66 MHz group taken from the external input |
| tristate_mode | output | 1 | Outputs held three-stated |
| test_mode | output | 1 | Test-clock mode |
| vco_en | output | 1 | VCO enable |
| out_en | output | 1 | Clock output enable |

## Verification
The supply is recognised `SYNC_STAGES`+1 edges after `supply_ok` rises. When `pg_n` is already low, the captured outputs are due one edge after the final settling tick. When the block is waiting, they are due `SYNC_STAGES`+1 edges after `pg_n` falls. The checks sample on the falling clock edge. For each path they confirm that nothing has changed one edge before the due edge and that every output is correct right after it. The frozen state is then rechecked after the straps and the strobe have been disturbed, and it must match the values computed from the captured straps.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

  localparam int STRAP_W = 5;
  localparam int MHZ_W   = 8;

  localparam logic [MHZ_W-1:0] MHZ_66  = 8'd66;
  localparam logic [MHZ_W-1:0] MHZ_100 = 8'd100;
  localparam logic [MHZ_W-1:0] MHZ_200 = 8'd200;
  localparam logic [MHZ_W-1:0] MHZ_133 = 8'd133;

  typedef enum logic [1:0] {
    PH_SUPPLY  = 2'd0,
    PH_SETTLE  = 2'd1,
    PH_WAIT_PG = 2'd2,
    PH_RUN     = 2'd3
  } phase_t;

  // bit 4 mult, bit 3 mid, bit 2 high, bits 1:0 low selects
  typedef struct packed {
    logic       mult;
    logic       hi_mid;
    logic       hi_high;
    logic [1:0] sel;
  } strap_t;

  typedef struct packed {
    logic [MHZ_W-1:0] mhz;
    logic             src_ext;
    logic             hiz;
    logic             test;
  } decode_t;

  function automatic logic [MHZ_W-1:0] code_to_mhz(input logic [1:0] code);
    case (code)
      2'd0:    return MHZ_66;
      2'd1:    return MHZ_100;
      2'd2:    return MHZ_200;
      default: return MHZ_133;
    endcase
  endfunction

endpackage

// File: rtl/cgs_sync.sv
module cgs_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cgs_settle_timer.sv
module cgs_settle_timer #(
  parameter int TICKS = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic done
);

  localparam int CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt;

  assign done = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= done ? '0 : cnt + 1'b1;
    end
  end

  // R2: count never leaves the window range
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(TICKS));

  // R2: the count only moves on a tick inside the window
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(run && tick)) |=> $stable(cnt));

endmodule

// File: rtl/cgs_strap_decode.sv
module cgs_strap_decode
  import cgs_pkg::*;
(
  input  strap_t  s,
  output decode_t d
);

  always_comb begin
    d = '0;
    if (s.hi_mid) begin
      if (s.sel == 2'b01) begin
        d.test = 1'b1;
        d.mhz  = MHZ_200;
      end else begin
        d.hiz  = 1'b1;
        d.mhz  = code_to_mhz(s.sel);
      end
    end else begin
      d.src_ext = s.hi_high;
      d.mhz     = code_to_mhz(s.sel);
    end
  end

endmodule

// File: rtl/clkgen_startup_seq.sv
module clkgen_startup_seq
  import cgs_pkg::*;
#(
  parameter int SETTLE_TICKS = 250,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               supply_ok,
  input  logic               pg_n,
  input  logic [1:0]         sel_lo,
  input  logic               sel_hi_high,
  input  logic               sel_hi_mid,
  input  logic               mult_sel,
  output logic [STRAP_W-1:0] strap_word,
  output logic [MHZ_W-1:0]   cpu_mhz,
  output logic               src_external,
  output logic               tristate_mode,
  output logic               test_mode,
  output logic               vco_en,
  output logic               out_en
);

  logic    supply_s;
  logic    pg_s;
  strap_t  strap_raw;
  strap_t  strap_s;
  strap_t  strap_q;
  decode_t dec_now;
  decode_t dec_q;
  phase_t  phase;
  logic    win_done;

  assign strap_raw = {mult_sel, sel_hi_mid, sel_hi_high, sel_lo};

  cgs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_supply (
    .clk(clk), .rst(rst), .d(supply_ok), .q(supply_s));

  cgs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pg (
    .clk(clk), .rst(rst), .d(pg_n), .q(pg_s));

  cgs_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_strap (
    .clk(clk), .rst(rst), .d(strap_raw), .q(strap_s));

  cgs_settle_timer #(.TICKS(SETTLE_TICKS)) u_timer (
    .clk(clk), .rst(rst),
    .clr(phase != PH_SETTLE),
    .run(phase == PH_SETTLE),
    .tick(tick),
    .done(win_done));

  cgs_strap_decode u_dec (.s(strap_s), .d(dec_now));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_SUPPLY;
      strap_q <= '0;
      dec_q   <= '0;
      vco_en  <= 1'b0;
      out_en  <= 1'b0;
    end else begin
      case (phase)
        PH_SUPPLY:  if (supply_s) phase <= PH_SETTLE;
        PH_SETTLE:  if (win_done) phase <= PH_WAIT_PG;
        PH_WAIT_PG: if (!pg_s) begin
          phase   <= PH_RUN;
          strap_q <= strap_s;
          dec_q   <= dec_now;
          vco_en  <= 1'b1;
          out_en  <= !dec_now.hiz;
        end
        default: ;
      endcase
    end
  end

  assign strap_word    = strap_q;
  assign cpu_mhz       = dec_q.mhz;
  assign src_external  = dec_q.src_ext;
  assign tristate_mode = dec_q.hiz;
  assign test_mode     = dec_q.test;

  // R3: nothing starts while the settling window is open
  p_window_masks_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SETTLE) |=> !vco_en);

  // R5: captured straps never move once running
  p_straps_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    vco_en |=> $stable(strap_word) && $stable(cpu_mhz));

  // R10: the VCO stays enabled
  p_run_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    vco_en |=> vco_en);

  // R10: outputs only with the VCO running
  p_out_needs_vco_r10: assert property (@(posedge clk) disable iff (rst)
    out_en |-> vco_en);

  // R8: three-state mode keeps outputs off, modes exclusive
  p_hiz_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    tristate_mode |-> !out_en && !test_mode);

  // R8: test mode runs at the 200 MHz setting
  p_test_rate_r8: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> (cpu_mhz == MHZ_200) && !src_external);

endmodule

// File: tb/tb_clkgen_startup_seq.sv
module tb_clkgen_startup_seq;

  localparam int TICKS = 250;
  localparam int SYNC  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       supply_ok = 1'b0;
  logic       pg_n = 1'b1;
  logic [1:0] sel_lo = 2'b00;
  logic       sel_hi_high = 1'b0;
  logic       sel_hi_mid = 1'b0;
  logic       mult_sel = 1'b0;
  logic [4:0] strap_word;
  logic [7:0] cpu_mhz;
  logic       src_external, tristate_mode, test_mode, vco_en, out_en;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  clkgen_startup_seq #(.SETTLE_TICKS(TICKS), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok), .pg_n(pg_n),
    .sel_lo(sel_lo), .sel_hi_high(sel_hi_high), .sel_hi_mid(sel_hi_mid),
    .mult_sel(mult_sel), .strap_word(strap_word), .cpu_mhz(cpu_mhz),
    .src_external(src_external), .tristate_mode(tristate_mode),
    .test_mode(test_mode), .vco_en(vco_en), .out_en(out_en));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_mhz(input logic [1:0] s, input logic hm);
    if (hm && s == 2'b01) return 200;
    case (s)
      2'd0: return 66;
      2'd1: return 100;
      2'd2: return 200;
      default: return 133;
    endcase
  endfunction

  function automatic int exp_hiz(input logic [1:0] s, input logic hm);
    return (hm && s != 2'b01) ? 1 : 0;
  endfunction

  function automatic int exp_test(input logic [1:0] s, input logic hm);
    return (hm && s == 2'b01) ? 1 : 0;
  endfunction

  function automatic int exp_src(input logic hh, input logic hm);
    return (!hm && hh) ? 1 : 0;
  endfunction

  task automatic check_captured(input string phase_tag, input logic [1:0] s,
                                input logic hh, input logic hm, input logic m);
    chk({phase_tag, " R9 strap_word"}, int'(strap_word), int'({m, hm, hh, s}));
    chk({phase_tag, " R6 cpu_mhz"}, int'(cpu_mhz), exp_mhz(s, hm));
    chk({phase_tag, " R7 src_external"}, int'(src_external), exp_src(hh, hm));
    chk({phase_tag, " R8 tristate_mode"}, int'(tristate_mode), exp_hiz(s, hm));
    chk({phase_tag, " R8 test_mode"}, int'(test_mode), exp_test(s, hm));
    chk({phase_tag, " R10 vco_en"}, int'(vco_en), 1);
    chk({phase_tag, " R10 out_en"}, int'(out_en), 1 - exp_hiz(s, hm));
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_straps(input logic [1:0] s, input logic hh, input logic hm,
                            input logic m);
    sel_lo = s; sel_hi_high = hh; sel_hi_mid = hm; mult_sel = m;
  endtask

  task automatic run_case(input logic [1:0] s, input logic hh, input logic hm,
                          input logic m, input bit early_pg);
    @(negedge clk);
    rst = 1'b1; supply_ok = 1'b0; pg_n = 1'b1; tick = 1'b0;
    set_straps(2'b00, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 vco_en in reset", int'(vco_en), 0);
    chk("R1 strap_word in reset", int'(strap_word), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_en after reset", int'(out_en), 0);
    chk("R1 cpu_mhz after reset", int'(cpu_mhz), 0);
    chk("R1 mode flags after reset",
        int'({src_external, tristate_mode, test_mode}), 0);
    // ticks while the supply is not up must not count
    do_ticks(3);
    chk("R2 vco_en before supply", int'(vco_en), 0);
    if (early_pg) begin
      set_straps(s, hh, hm, m);
      pg_n = 1'b0;
    end
    supply_ok = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    if (early_pg) begin
      do_ticks(TICKS - 1);
      chk("R2 vco_en before final tick", int'(vco_en), 0);
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      chk("R2 vco_en at final tick edge", int'(vco_en), 0);
      @(negedge clk);
      check_captured("R2 early", s, hh, hm, m);
    end else begin
      set_straps(~s, ~hh, ~hm, ~m);
      do_ticks(TICKS / 2);
      pg_n = 1'b0;
      repeat (3) @(negedge clk);
      pg_n = 1'b1;
      do_ticks(TICKS - TICKS / 2);
      repeat (10) @(negedge clk);
      chk("R3 vco_en while waiting", int'(vco_en), 0);
      chk("R3 out_en while waiting", int'(out_en), 0);
      chk("R3 strap_word while waiting", int'(strap_word), 0);
      set_straps(s, hh, hm, m);
      repeat (SYNC + 2) @(negedge clk);
      pg_n = 1'b0;
      repeat (SYNC) @(negedge clk);
      chk("R4 vco_en one edge early", int'(vco_en), 0);
      @(negedge clk);
      check_captured("R4 capture", s, hh, hm, m);
    end
    for (int k = 0; k < 4; k++) begin
      pg_n = $urandom_range(1, 0);
      set_straps(2'($urandom), 1'($urandom), 1'($urandom), ~m);
      repeat (SYNC + 2) @(negedge clk);
    end
    check_captured("R5 frozen", s, hh, hm, m);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (2) @(negedge clk);
    // directed: each select code, each mid code, mid over high
    run_case(2'b00, 1'b1, 1'b0, 1'b0, 1'b1);
    run_case(2'b01, 1'b0, 1'b0, 1'b1, 1'b1);
    run_case(2'b10, 1'b1, 1'b0, 1'b1, 1'b0);
    run_case(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    run_case(2'b00, 1'b0, 1'b1, 1'b0, 1'b1);
    run_case(2'b01, 1'b0, 1'b1, 1'b1, 1'b0);
    run_case(2'b10, 1'b0, 1'b1, 1'b0, 1'b1);
    run_case(2'b11, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int r = 0; r < 8; r++) begin
      run_case(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule